// File: doc/BRIEF.md
# Clock Calendar Counter

This block counts time of day and calendar date inside a larger chip. A free-running enable, `tick_i`, arrives at the 32.768 kHz reference rate. An internal prescaler divides it down to one advance per second. The time is held as six BCD fields (seconds, minutes, hours, date, month and two-digit year) plus a day-of-week count. Carries ripple from seconds up through the year. Month lengths and leap years for 2000 to 2099 are handled by the counter itself, so the host never has to fix up the 29th of February.

A host loads any single field through a parallel write port that takes a selector and a data byte. All fields are visible at all times on the read outputs. Each write restarts the sub-second prescaler. A write also cancels any advance that falls due in the same cycle. `sec_pulse_o` marks every one-second advance so that a neighbouring alarm unit can compare the fields exactly once per second.

Top module: `cal_clock_top`

## Requirements
- R1: After reset the outputs read 00:00:00, date 01, month 01, year 00, day-of-week 0, and `sec_pulse_o` is low.
- R2: The time advances by one second after every `DIV_COUNT` cycles in which `tick_i` is high. The new values appear two clock edges after the edge that samples the final tick, and `sec_pulse_o` is high for exactly that one cycle.
- R3: Seconds and minutes count in BCD from 00 to 59. Going from 59 to 00 carries into the next field.
- R4: Hours count in BCD from 00 to 23 (24-hour format). Going from 23 to 00 advances the date.
- R5: Date wraps to 01 after the last day of the month. That last day is 30 for months 04, 06, 09 and 11, 28 for month 02 in a non-leap year, and 31 for all other months.
- R6: A year whose two-digit value is divisible by 4, including 00, is a leap year, and February then ends on 29.
- R7: After the last day of month 12 the month wraps to 01 and the year advances. Year 99 wraps to 00.
- R8: Day-of-week advances by one on every date advance and wraps from 6 to 0.
- R9: While `wr_en_i` is high, `wr_sel_i` picks the field that takes `wr_data_i` on the next edge. The codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, and 6 day-of-week (bits 2:0 of the data). The new value is visible the following cycle.
- R10: A write with a selector from 0 to 6 clears the prescaler. The next advance then needs a full `DIV_COUNT` ticks after the write.
- R11: A write with a selector from 0 to 6 takes priority over an advance due in the same cycle. That advance is dropped, no field other than the written one changes, and no pulse is produced.
- R12: A write with selector 7 has no effect. No field changes, and the prescaler keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz rate enable |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Field selector for writes |
| wr_data_i | input | 8 | BCD write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, 24-hour |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within the century, BCD |
| dow_o | output | 3 | Day of week, 0 to 6 |
| sec_pulse_o | output | 1 | One-cycle pulse on each second advance |

## Verification
A prescaler count that is off shifts `sec_pulse_o` and the seconds change by whole cycles within the first second, so cycle-exact comparison catches it at once. A wrong field limit or leap decision stays hidden until that field rolls over. For that reason the stimulus repeatedly loads states one second before a month, year or century boundary and then watches the next advance. An error in day-of-week or in write priority shows up on the very next edge after the triggering event.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned DOW_W      = 3;

  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DATE  = 3'd3,
    SEL_MONTH = 3'd4,
    SEL_YEAR  = 3'd5,
    SEL_DOW   = 3'd6,
    SEL_NONE  = 3'd7
  } field_sel_e;

  function automatic logic [FIELD_W-1:0] bcd_next(input logic [FIELD_W-1:0] v);
    if (v[3:0] == 4'd9) bcd_next = {v[7:4] + 4'd1, 4'd0};
    else                bcd_next = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // tens*10 + ones mod 4 == (2*tens[0] + ones) mod 4
  function automatic logic year_is_leap(input logic [FIELD_W-1:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    year_is_leap = (r == 2'd0);
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned DIV_COUNT = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic stb_o
);
  localparam int unsigned CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_o <= 1'b0;
    end else begin
      stb_o <= tick_i && at_last && !clr_i;
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
    end
  end

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  a_r10_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!stb_o && cnt_q == '0));
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] LOW = 8'h00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_i,
  input  logic [FIELD_W-1:0] ld_data_i,
  input  logic               inc_i,
  input  logic [FIELD_W-1:0] max_i,
  output logic [FIELD_W-1:0] q_o,
  output logic               carry_o
);
  logic at_max;
  assign at_max  = (q_o == max_i);
  assign carry_o = inc_i && !ld_i && at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= LOW;
    else if (ld_i)  q_o <= ld_data_i;
    else if (inc_i) q_o <= at_max ? LOW : bcd_next(q_o);
  end

  a_r3_carry_wraps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> (q_o == LOW));
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [FIELD_W-1:0] month_i,
  input  logic [FIELD_W-1:0] year_i,
  output logic [FIELD_W-1:0] last_o
);
  always_comb begin
    unique case (month_i)
      8'h02:                      last_o = year_is_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
  import cal_pkg::*;
#(
  parameter int unsigned DIV_COUNT = 32768
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_sel_i,
  input  logic [FIELD_W-1:0]   wr_data_i,
  output logic [FIELD_W-1:0]   sec_o,
  output logic [FIELD_W-1:0]   min_o,
  output logic [FIELD_W-1:0]   hour_o,
  output logic [FIELD_W-1:0]   date_o,
  output logic [FIELD_W-1:0]   month_o,
  output logic [FIELD_W-1:0]   year_o,
  output logic [DOW_W-1:0]     dow_o,
  output logic                 sec_pulse_o
);
  localparam int unsigned F_HOUR  = 2;
  localparam int unsigned F_DATE  = 3;
  localparam int unsigned F_MONTH = 4;
  localparam int unsigned F_YEAR  = 5;

  logic               wr_any, sec_stb, adv;
  logic               inc   [NUM_FIELDS+1];
  logic               carry [NUM_FIELDS];
  logic [FIELD_W-1:0] lim   [NUM_FIELDS];
  logic [FIELD_W-1:0] q     [NUM_FIELDS];
  logic [FIELD_W-1:0] month_last;
  logic               day_roll;
  logic [DOW_W-1:0]   dow_q;
  logic               pulse_q;

  assign wr_any = wr_en_i && (wr_sel_i != SEL_NONE);
  assign adv    = sec_stb && !wr_any;   // write wins over a due advance

  cal_prescaler #(.DIV_COUNT(DIV_COUNT)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (wr_any),
    .stb_o  (sec_stb)
  );

  cal_month_len u_mlen (
    .month_i (q[F_MONTH]),
    .year_i  (q[F_YEAR]),
    .last_o  (month_last)
  );

  always_comb begin
    lim[0]       = 8'h59;
    lim[1]       = 8'h59;
    lim[F_HOUR]  = 8'h23;
    lim[F_DATE]  = month_last;
    lim[F_MONTH] = 8'h12;
    lim[F_YEAR]  = 8'h99;
  end

  assign inc[0] = adv;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [FIELD_W-1:0] LO = (i == F_DATE || i == F_MONTH) ? 8'h01 : 8'h00;
    logic ld;
    assign ld = wr_en_i && (wr_sel_i == 3'(i));

    cal_bcd_field #(.LOW(LO)) u_fld (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (ld),
      .ld_data_i (wr_data_i),
      .inc_i     (inc[i]),
      .max_i     (lim[i]),
      .q_o       (q[i]),
      .carry_o   (carry[i])
    );

    assign inc[i+1] = carry[i];
  end

  assign day_roll = carry[F_HOUR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dow_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= adv;
      if (wr_en_i && wr_sel_i == SEL_DOW) dow_q <= wr_data_i[DOW_W-1:0];
      else if (day_roll)                  dow_q <= (dow_q == 3'd6) ? '0 : dow_q + 3'd1;
    end
  end

  assign sec_o       = q[0];
  assign min_o       = q[1];
  assign hour_o      = q[F_HOUR];
  assign date_o      = q[F_DATE];
  assign month_o     = q[F_MONTH];
  assign year_o      = q[F_YEAR];
  assign dow_o       = dow_q;
  assign sec_pulse_o = pulse_q;

  a_r2_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |=> !sec_pulse_o);

  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_SEC) |=> (sec_o == $past(wr_data_i) && !sec_pulse_o));

  a_r12_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && !sec_stb) |=>
      ($stable({sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o}) && !sec_pulse_o));

  a_r8_dow_follows_date: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_o && date_o != $past(date_o)) |->
      (dow_o == (($past(dow_o) == 3'd6) ? 3'd0 : 3'($past(dow_o) + 3'd1))));

  a_r4_hour_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_o && $past(hour_o) == 8'h23 && hour_o != 8'h23) |-> (hour_o == 8'h00));
endmodule

// File: tb/cal_clock_top_test.sv
`timescale 1ns/100ps
module cal_clock_top_test;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, we = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] wdat = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] dow_o;
  logic       pulse_o;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // bench model
  int m_cnt, m_s, m_mi, m_h, m_d, m_mo, m_y, m_dw;
  bit m_stb, m_pulse, m_wr, m_adv;

  always #2.5 clk = ~clk;

  cal_clock_top #(.DIV_COUNT(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we), .wr_sel_i(sel),
    .wr_data_i(wdat), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .dow_o(dow_o),
    .sec_pulse_o(pulse_o)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_advance();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0; m_dw = (m_dw + 1) % 7; m_d++;
          if (m_d > days_in(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_stb = 0; m_pulse = 0;
      m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_dw = 0;
    end else begin
      m_wr    = we && (sel != 3'd7);
      m_adv   = m_stb && !m_wr;
      m_pulse = m_adv;
      m_stb   = tick && (m_cnt == DIV - 1) && !m_wr;
      if (m_wr)      m_cnt = 0;
      else if (tick) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      if (m_wr) begin
        case (sel)
          3'd0: m_s  = from_bcd(wdat);
          3'd1: m_mi = from_bcd(wdat);
          3'd2: m_h  = from_bcd(wdat);
          3'd3: m_d  = from_bcd(wdat);
          3'd4: m_mo = from_bcd(wdat);
          3'd5: m_y  = from_bcd(wdat);
          default: m_dw = int'(wdat[2:0]);
        endcase
      end else if (m_adv) model_advance();
    end
  end

  always @(negedge clk) begin
    logic [50:0] got, exp;
    if (!done) begin
      got = {sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o, pulse_o};
      exp = {to_bcd(m_s), to_bcd(m_mi), to_bcd(m_h), to_bcd(m_d), to_bcd(m_mo),
             to_bcd(m_y), 3'(m_dw), m_pulse};
      n_cmp++;
      if (got !== exp) begin
        n_bad++;
        $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, got, exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(input bit t, input bit w, input logic [2:0] s, input logic [7:0] d);
    tick = t; we = w; sel = s; wdat = d;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input int v);
    step(1'b0, 1'b1, s, (s == 3'd6) ? 8'(v) : to_bcd(v));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic set_all(input int h, input int mi, input int s, input int d,
                         input int mo, input int y, input int dw);
    wr(3'd5, y); wr(3'd4, mo); wr(3'd3, d); wr(3'd2, h);
    wr(3'd1, mi); wr(3'd6, dw); wr(3'd0, s);
  endtask

  task automatic boundary(input string t, input int d, input int mo, input int y, input int dw);
    tag = t;
    set_all(23, 59, 59, d, mo, y, dw);
    ticks(DIV); idle(3);
  endtask

  initial begin
    void'($urandom(32'd20250));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; idle(3);

    tag = "R2"; ticks(DIV * 3); idle(2);
    for (int i = 0; i < 3 * DIV; i++) step(i % 2 == 0, 1'b0, 3'd0, 8'h00);
    idle(3);

    tag = "R3"; set_all(10, 58, 57, 5, 6, 21, 2); ticks(DIV * 5); idle(3);
    boundary("R4", 10, 3, 22, 1);
    boundary("R5", 30, 4, 23, 3);
    boundary("R5", 31, 1, 23, 0);
    boundary("R5", 28, 2, 1, 4);
    boundary("R5", 30, 11, 9, 5);
    boundary("R6", 28, 2, 4, 2);
    boundary("R6", 29, 2, 4, 3);
    boundary("R6", 28, 2, 0, 6);
    boundary("R6", 28, 2, 96, 1);
    boundary("R7", 31, 12, 99, 5);
    boundary("R7", 31, 12, 41, 0);
    boundary("R8", 15, 7, 30, 6);

    tag = "R9";
    for (int s = 0; s < 7; s++) begin wr(3'(s), (s == 3 || s == 4) ? 7 : 3 + s); idle(1); end

    tag = "R10"; ticks(DIV - 2); wr(3'd1, 12); ticks(DIV - 1); idle(2); ticks(2); idle(2);

    tag = "R11"; ticks(DIV - 1);
    step(1'b1, 1'b1, 3'd0, 8'h42); idle(2);
    ticks(DIV); wr(3'd2, 5); idle(3);
    ticks(DIV); wr(3'd0, 30); idle(3);

    tag = "R12"; ticks(DIV - 3); step(1'b0, 1'b1, 3'd7, 8'h77); ticks(3); idle(3);

    tag = "R2";
    for (int i = 0; i < 30000; i++) begin
      int r;
      r = int'($urandom % 200);
      if (r < 4) begin
        int s, v;
        s = int'($urandom % 7);
        if (s == 4 && m_d > 28) s = 3;
        case (s)
          0, 1: v = int'($urandom % 60);
          2: v = int'($urandom % 24);
          3: v = 1 + int'($urandom % 28);
          4: v = 1 + int'($urandom % 12);
          5: v = int'($urandom % 100);
          default: v = int'($urandom % 7);
        endcase
        wr(3'(s), v);
      end else if (r < 6) begin
        step(1'b0, 1'b1, 3'd7, 8'($urandom));
      end else if (r < 7) begin
        wr(3'd2, 23); wr(3'd1, 59); wr(3'd0, 50 + int'($urandom % 10));
      end else begin
        step(r < 150, 1'b0, 3'd0, 8'h00);
      end
    end
    idle(3);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule